// File: doc/BRIEF.md
# Pixel Hit Latch and Timestamp Cell

This block is the digital half of one pixel in a sparsified sensor matrix. While the train is running, a 5-bit register in the cell copies the shared timestamp bus on every clock edge. The first discriminator pulse seen in the detection window sets a hit latch. From that edge on, the register holds the bus value that was captured there. Each pixel therefore stores exactly one hit per train.

During readout a token ripples through the matrix. A cell with no stored hit passes the token combinationally to its neighbour. A hit cell stops the token. While it holds the token, it drives its frozen stamp onto its timestamp output and raises its row and column select lines to the periphery. When the periphery pulses the read-done strobe, the cell drops its hit state at the next edge and lets the token go on. A synchronous master reset clears the cell before the next train.

Top module: `pix_cell`

## Requirements
- R1: A clock edge with `rst_n` low clears the hit state, and this wins over a hit presented at the same edge. After it, `tok_out` follows `tok_in` and all select and timestamp outputs are 0.
- R2: A clock edge with `det_phase` = 1 and `hit_in` = 1 sets the hit state. After that edge, `tok_out` stays 0 while `tok_in` is 1.
- R3: While unhit, the stored stamp loads `ts_bus` on every edge. The value kept is the `ts_bus` value at the edge that records the hit, and later bus changes have no effect on it. All 5-bit values, including 31, are held.
- R4: A `hit_in` pulse at an edge with `det_phase` = 0 is ignored, and the cell keeps passing the token.
- R5: A cell without a stored hit drives `tok_out` equal to `tok_in` within the same cycle, with no clock edge in between.
- R6: A hit cell with `tok_in` = 1 owns the token. It drives `sel_x` = 1, `sel_y` = 1 and `ts_out` = the stored stamp, and `tok_out` = 0.
- R7: `rd_done` = 1 at an edge while the cell owns the token clears the hit state. After that edge, `tok_out` follows `tok_in` and the outputs return to 0.
- R8: `rd_done` at an edge where the cell does not own the token (`tok_in` = 0) has no effect, and the stored hit is still read out later.
- R9: When the cell does not own the token, `ts_out`, `sel_x` and `sel_y` are all 0, even if a hit is stored.
- R10: A second hit in the same detection window neither changes the stored stamp nor alters the token behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| det_phase | input | 1 | High during the detection window of a train |
| hit_in | input | 1 | Discriminator output |
| ts_bus | input | 5 | Running timestamp shared by the matrix |
| tok_in | input | 1 | Token from the previous cell |
| rd_done | input | 1 | Periphery strobe confirming the owned data was taken |
| tok_out | output | 1 | Token to the next cell |
| sel_x | output | 1 | Column select to the periphery |
| sel_y | output | 1 | Row select to the periphery |
| ts_out | output | 5 | Stored stamp, nonzero only while the token is owned |

## Verification
The assertions take as given that `rd_done` means a read only while the token sits in this cell. They also assume that `tok_in`, once raised during readout, stays high until the owning cell releases it. The stimulus holds `tok_in` steady across each owning period, and it pulses `rd_done` either during ownership or deliberately with `tok_in` low. Hits are applied both inside and outside the detection window, and a reset is applied in the same cycle as a hit.

// File: rtl/pix_cell_pkg.sv
// Package: shared constants for the pixel cell.
// Assumes: the matrix timestamp bus is CELL_TS_W bits wide.
package pix_cell_pkg;
    localparam int CELL_TS_W = 5;
endpackage

// File: rtl/pix_hit_latch.sv
// Module: one-hit-per-train latch.
// Sets on a discriminator pulse inside the detection window and is cleared
// by reset or by the token logic after a completed read. Clear wins over set.
module pix_hit_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic det_phase_i,
    input  logic hit_i,
    input  logic clr_i,
    output logic hit_q
);
    logic set_w;

    // qualify the discriminator pulse with the detection window
    always_comb set_w = det_phase_i & hit_i;

    // latch state: reset, clear after read, then set
    always_ff @(posedge clk) begin
        if (!rst_n)      hit_q <= 1'b0;
        else if (clr_i)  hit_q <= 1'b0;
        else if (set_w)  hit_q <= 1'b1;
    end

    AST_NO_HIT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_phase_i && !hit_q) |=> !hit_q); // R4
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !hit_q); // R7
endmodule

// File: rtl/pix_ts_reg.sv
// Module: per-pixel timestamp register.
// Follows the shared bus while no hit is stored, and freezes once the
// latch is set. The value captured is the bus at the hit-recording edge.
module pix_ts_reg #(
    parameter int TS_W = pix_cell_pkg::CELL_TS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_i,
    input  logic [TS_W-1:0] ts_bus_i,
    output logic [TS_W-1:0] ts_q
);
    // track the bus until hold, then keep the value
    always_ff @(posedge clk) begin
        if (!rst_n)       ts_q <= '0;
        else if (!hold_i) ts_q <= ts_bus_i;
    end

    AST_TS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (ts_q == $past(ts_q))); // R3
endmodule

// File: rtl/pix_token_ctl.sv
// Module: token catch/pass logic.
// An unhit cell forwards the token combinationally. A hit cell keeps it,
// drives its stamp and select lines, and requests a latch clear on rd_done.
// Assumes: rd_done from the periphery is meaningful only while owned.
module pix_token_ctl #(
    parameter int TS_W = pix_cell_pkg::CELL_TS_W
) (
    input  logic            tok_in_i,
    input  logic            hit_q_i,
    input  logic [TS_W-1:0] ts_q_i,
    input  logic            rd_done_i,
    output logic            tok_out_o,
    output logic            sel_x_o,
    output logic            sel_y_o,
    output logic [TS_W-1:0] ts_out_o,
    output logic            clr_o
);
    logic own_w;

    // ownership: token present and a hit stored
    always_comb own_w = tok_in_i & hit_q_i;

    // forward the token only when no hit is stored
    always_comb tok_out_o = tok_in_i & ~hit_q_i;

    // drive select lines and stamp only while owned
    always_comb begin
        sel_x_o  = own_w;
        sel_y_o  = own_w;
        ts_out_o = own_w ? ts_q_i : '0;
    end

    // release request after the periphery confirms the read
    always_comb clr_o = own_w & rd_done_i;

    always_comb begin
        if (!(tok_out_o && own_w)) begin end
        else AST_TOKEN_EXCL: assert (1'b0); // R6
    end
endmodule

// File: rtl/pix_cell.sv
// Module: top of the pixel digital section.
// Couples the hit latch, timestamp register and token logic.
// Assumes: tok_in stays high while this cell owns the token.
module pix_cell #(
    parameter int TS_W = pix_cell_pkg::CELL_TS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            det_phase,
    input  logic            hit_in,
    input  logic [TS_W-1:0] ts_bus,
    input  logic            tok_in,
    input  logic            rd_done,
    output logic            tok_out,
    output logic            sel_x,
    output logic            sel_y,
    output logic [TS_W-1:0] ts_out
);
    logic            hit_q;
    logic            clr_w;
    logic [TS_W-1:0] ts_q;

    pix_hit_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .det_phase_i (det_phase),
        .hit_i       (hit_in),
        .clr_i       (clr_w),
        .hit_q       (hit_q)
    );

    pix_ts_reg #(.TS_W(TS_W)) u_ts (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (hit_q),
        .ts_bus_i (ts_bus),
        .ts_q     (ts_q)
    );

    pix_token_ctl #(.TS_W(TS_W)) u_tok (
        .tok_in_i  (tok_in),
        .hit_q_i   (hit_q),
        .ts_q_i    (ts_q),
        .rd_done_i (rd_done),
        .tok_out_o (tok_out),
        .sel_x_o   (sel_x),
        .sel_y_o   (sel_y),
        .ts_out_o  (ts_out),
        .clr_o     (clr_w)
    );

    AST_QUIET_NO_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_in |-> (ts_out == '0 && !sel_x && !sel_y && !tok_out)); // R9
    AST_SEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        sel_x == sel_y); // R6
    AST_PASS_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |-> !sel_x); // R5
endmodule

// File: tb/pix_cell_bench.sv
module pix_cell_bench;
    logic       clk = 1'b0;
    logic       rst_n, det_phase, hit_in, tok_in, rd_done;
    logic [4:0] ts_bus;
    logic       tok_out, sel_x, sel_y;
    logic [4:0] ts_out;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pix_cell u_pix_cell (
        .clk(clk), .rst_n(rst_n), .det_phase(det_phase), .hit_in(hit_in),
        .ts_bus(ts_bus), .tok_in(tok_in), .rd_done(rd_done),
        .tok_out(tok_out), .sel_x(sel_x), .sel_y(sel_y), .ts_out(ts_out)
    );

    // fields: rst_n det hit ts tok rd | exp_tok exp_sel exp_ts | req
    typedef struct packed {
        logic       rst;
        logic       det;
        logic       hit;
        logic [4:0] ts;
        logic       tok;
        logic       rd;
        logic       e_tok;
        logic       e_sel;
        logic [4:0] e_ts;
        logic [7:0] req;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0, 1'b0,1'b0,5'd0, 8'd1},
        '{1'b1,1'b1,1'b0,5'd3, 1'b1,1'b0, 1'b1,1'b0,5'd0, 8'd5},
        '{1'b1,1'b1,1'b1,5'd9, 1'b0,1'b0, 1'b0,1'b0,5'd0, 8'd2},
        '{1'b1,1'b1,1'b0,5'd12,1'b0,1'b0, 1'b0,1'b0,5'd0, 8'd9},
        '{1'b1,1'b1,1'b1,5'd20,1'b0,1'b0, 1'b0,1'b0,5'd0, 8'd10},
        '{1'b1,1'b0,1'b0,5'd7, 1'b1,1'b0, 1'b0,1'b1,5'd9, 8'd3},
        '{1'b1,1'b0,1'b0,5'd7, 1'b1,1'b1, 1'b0,1'b1,5'd9, 8'd6},
        '{1'b1,1'b0,1'b0,5'd4, 1'b1,1'b0, 1'b1,1'b0,5'd0, 8'd7},
        '{1'b1,1'b0,1'b1,5'd5, 1'b1,1'b0, 1'b1,1'b0,5'd0, 8'd4},
        '{1'b1,1'b0,1'b0,5'd6, 1'b1,1'b0, 1'b1,1'b0,5'd0, 8'd4},
        '{1'b1,1'b1,1'b1,5'd17,1'b0,1'b1, 1'b0,1'b0,5'd0, 8'd8},
        '{1'b1,1'b0,1'b0,5'd2, 1'b0,1'b1, 1'b0,1'b0,5'd0, 8'd9},
        '{1'b1,1'b0,1'b0,5'd2, 1'b1,1'b0, 1'b0,1'b1,5'd17,8'd8},
        '{1'b0,1'b0,1'b0,5'd2, 1'b1,1'b0, 1'b0,1'b1,5'd17,8'd6},
        '{1'b1,1'b0,1'b0,5'd2, 1'b1,1'b0, 1'b1,1'b0,5'd0, 8'd1}
    };

    task automatic drive(input logic r, input logic d, input logic h,
                         input logic [4:0] t, input logic k, input logic rd);
        @(negedge clk);
        rst_n = r; det_phase = d; hit_in = h; ts_bus = t; tok_in = k; rd_done = rd;
        #1;
    endtask

    task automatic expect_out(input logic et, input logic es, input logic [4:0] ets,
                              input string req);
        checks++;
        if (tok_out !== et || sel_x !== es || sel_y !== es || ts_out !== ets) begin
            failures++;
            $display("FAIL %s: tok_out=%b sel_x=%b sel_y=%b ts_out=%0d expected tok_out=%b sel=%b ts_out=%0d",
                     req, tok_out, sel_x, sel_y, ts_out, et, es, ets);
        end
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; det_phase = 1'b0; hit_in = 1'b0; ts_bus = '0;
        tok_in = 1'b0; rd_done = 1'b0;
        // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
        foreach (VECS[i]) begin
            drive(VECS[i].rst, VECS[i].det, VECS[i].hit, VECS[i].ts,
                  VECS[i].tok, VECS[i].rd);
            expect_out(VECS[i].e_tok, VECS[i].e_sel, VECS[i].e_ts,
                       $sformatf("R%0d(vec %0d)", VECS[i].req, i));
        end

        // R1: reset wins over a hit at the same edge
        drive(1'b0, 1'b1, 1'b1, 5'd11, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 5'd11, 1'b1, 1'b0);
        expect_out(1'b1, 1'b0, 5'd0, "R1 reset beats hit");

        // R3: maximum stamp value captured and held across bus changes
        drive(1'b1, 1'b1, 1'b1, 5'd31, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 5'd1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0);
        expect_out(1'b0, 1'b1, 5'd31, "R3 max stamp held");

        // R5: pass-through is combinational within one cycle
        drive(1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1);
        drive(1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
        expect_out(1'b0, 1'b0, 5'd0, "R5 token low");
        tok_in = 1'b1; #0.5;
        expect_out(1'b1, 1'b0, 5'd0, "R5 token rise same cycle");
        tok_in = 1'b0; #0.5;
        expect_out(1'b0, 1'b0, 5'd0, "R5 token fall same cycle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule